// File: doc/BRIEF.md
# Three-Bank Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines into three banks of 32 and routes each line to one of two processor outputs: a normal request and a fast request. Each line carries a 6-bit priority and a route bit. Each bank holds a mask, a set of software-raised interrupts, and a pending state. The pending state combines the live input levels with the software bits. When asked to evaluate, a priority resolver picks the winning line for each output. Lower priority values win. When priorities tie, the higher line index wins.

Each output follows an agreement handshake. Once an output asserts, its vector is latched and the output stays high until software writes the matching re-arm bit. A global mask blocks every new assertion. The register window is 4 KB of 32-bit words, addressed here by word index (byte address bits 11:2). Register reads are combinational and have no side effects.

Top module: `multi_bank_intc`

## Requirements
- R1: Fixed and simple global registers read back as follows: byte 0x000 reads 0x21; byte 0x014 reads 1; byte 0x010 bit 0 holds the autoidle bit; byte 0x050 bits 1:0 hold a 2-bit idle field; byte 0x048 bit 2 reads back the global mask.
- R2: A rising input level sets its pending bit at the next clock edge. Byte 0x80+0x20*bank reads the bank's registered raw levels. With the line unmasked and its output armed, the output asserts one edge after the pending update.
- R3: For each bank, byte +0x18 reads pending AND NOT mask AND NOT route, and byte +0x1C reads pending AND NOT mask AND route.
- R4: The word at byte 0x100+4*line holds the priority in bits 7:2 and the route bit in bit 0 (1 = fast). The resolver picks the lowest priority value, and on a tie the highest line index. The winning line number appears at byte 0x040 (normal) or byte 0x044 (fast).
- R5: An asserted output stays high, with its vector unchanged, until a write to byte 0x048 sets bit 0 (normal) or bit 1 (fast). That write drops the output at its own edge, re-arms it, and triggers a new evaluation.
- R6: While the global mask (byte 0x048 bit 2) is set, neither output can assert. Clearing it together with a re-arm lets the output assert again.
- R7: A bank's mask resets to all ones. Writing +0x04 replaces the mask and writing +0x08 clears the written bits; both trigger evaluation. Writing +0x0C sets the written bits and does not trigger evaluation.
- R8: Writing +0x10 ORs the value into the software bits and into the pending bits, then evaluates; +0x10 reads back the software bits. Writing +0x14 clears the written software bits and sets pending to the remaining software bits OR the live inputs. Any falling input in a bank sets that bank's pending to the live inputs OR the software bits.
- R9: Reading the vector registers does not clear pending state or change the vector.
- R10: Writing byte 0x010 with bit 1 set is a soft reset. It restores all masks to ones, clears pending bits, software bits, priorities, routes, autoidle and idle, and drops both outputs with their vectors set to 0.
- R11: Accesses to bank index 3 (bytes 0x0E0-0x0FF) and to line words beyond line 95 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 10 | Register word index (byte address bits 11:2) |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for regAddr |
| lineIn | input | 96 | Level-sensitive interrupt inputs, active high |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Read data is due in the same cycle as the address. Register writes take effect at the edge that samples them. An input change updates pending state at the first edge. An output asserts at the second edge after the input change or evaluating write, because the evaluation request is registered in between. A re-arm drops the output at the write's own edge and re-asserts it at the next edge. The bench drives every stimulus on a falling edge and samples on a falling edge after counting exactly those edges. It also samples one edge early to confirm that the output has not yet asserted.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // write strobes from the control decoder to the bank datapath
  typedef struct packed {
    logic wrMask;
    logic wrMaskClr;
    logic wrMaskSet;
    logic wrSwSet;
    logic wrSwClr;
    logic wrLine;
    logic softRst;
  } dpStrobe_t;
endpackage

// File: rtl/intc_prio_resolve.sv
module intc_prio_resolve #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = 7
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 anyHit,
  output logic [IW-1:0]        bestIdx
);
  logic [PW-1:0] bestPrio;

  // ascending scan with <= so that on equal priority the higher index wins
  always_comb begin
    anyHit   = 1'b0;
    bestIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!anyHit || prio[i] <= bestPrio)) begin
        anyHit   = 1'b1;
        bestPrio = prio[i];
        bestIdx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NB  = 3,
  parameter int LPB = 32,
  parameter int PW  = 6,
  parameter int NL  = 96,
  parameter int IW  = 7,
  parameter int BW  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strb,
  input  logic [BW-1:0]   bankSel,
  input  logic [IW-1:0]   lineSel,
  input  logic [LPB-1:0]  wrData,
  input  logic [NL-1:0]   lineIn,
  output logic [LPB-1:0]  rdRaw,
  output logic [LPB-1:0]  rdMask,
  output logic [LPB-1:0]  rdSw,
  output logic [LPB-1:0]  rdPendN,
  output logic [LPB-1:0]  rdPendF,
  output logic [PW-1:0]   rdPrio,
  output logic            rdFast,
  output logic            evalReq,
  output logic            anyNorm,
  output logic            anyFast,
  output logic [IW-1:0]   bestNorm,
  output logic [IW-1:0]   bestFast
);
  logic [NL-1:0][PW-1:0] prioQ;
  logic [NL-1:0]         fastQ;
  logic [NL-1:0]         pendFlat, maskFlat;
  logic [NB-1:0]         riseAny;
  logic [LPB-1:0]        rawAll [NB];
  logic [LPB-1:0]        maskAll [NB];
  logic [LPB-1:0]        swAll [NB];
  logic [LPB-1:0]        pnAll [NB];
  logic [LPB-1:0]        pfAll [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [LPB-1:0] maskQ, pendQ, swQ, inQ;
    logic [LPB-1:0] maskN, pendN, swN, liveB, riseB, routeB;
    logic           fallB, hitB;

    assign liveB  = lineIn[b*LPB +: LPB];
    assign routeB = fastQ[b*LPB +: LPB];
    assign riseB  = liveB & ~inQ;
    assign fallB  = |(inQ & ~liveB);
    assign hitB   = (bankSel == BW'(b));

    always_comb begin
      swN   = swQ;
      maskN = maskQ;
      if (hitB && strb.wrSwSet) swN = swQ | wrData;
      if (hitB && strb.wrSwClr) swN = swQ & ~wrData;
      pendN = fallB ? (liveB | swN) : (pendQ | riseB);
      if (hitB && strb.wrSwSet)   pendN = pendN | wrData;
      if (hitB && strb.wrSwClr)   pendN = swN | liveB;
      if (hitB && strb.wrMask)    maskN = wrData;
      if (hitB && strb.wrMaskClr) maskN = maskQ & ~wrData;
      if (hitB && strb.wrMaskSet) maskN = maskQ | wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ <= '1;
        pendQ <= '0;
        swQ   <= '0;
        inQ   <= '0;
      end else begin
        inQ <= liveB;
        if (strb.softRst) begin
          maskQ <= '1;
          pendQ <= '0;
          swQ   <= '0;
        end else begin
          maskQ <= maskN;
          pendQ <= pendN;
          swQ   <= swN;
        end
      end
    end

    assign riseAny[b]               = |riseB;
    assign rawAll[b]                = inQ;
    assign maskAll[b]               = maskQ;
    assign swAll[b]                 = swQ;
    assign pnAll[b]                 = pendQ & ~maskQ & ~routeB;
    assign pfAll[b]                 = pendQ & ~maskQ & routeB;
    assign pendFlat[b*LPB +: LPB]   = pendQ;
    assign maskFlat[b*LPB +: LPB]   = maskQ;
  end

  // per-line priority and route
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioQ <= '0;
      fastQ <= '0;
    end else if (strb.softRst) begin
      prioQ <= '0;
      fastQ <= '0;
    end else if (strb.wrLine) begin
      prioQ[lineSel] <= wrData[PW+1:2];
      fastQ[lineSel] <= wrData[0];
    end
  end

  logic bankOk;
  assign bankOk  = (32'(bankSel) < NB);
  assign rdRaw   = bankOk ? rawAll[bankSel]  : '0;
  assign rdMask  = bankOk ? maskAll[bankSel] : '0;
  assign rdSw    = bankOk ? swAll[bankSel]   : '0;
  assign rdPendN = bankOk ? pnAll[bankSel]   : '0;
  assign rdPendF = bankOk ? pfAll[bankSel]   : '0;
  assign rdPrio  = prioQ[lineSel];
  assign rdFast  = fastQ[lineSel];

  assign evalReq = (|riseAny) | strb.wrMask | strb.wrMaskClr | strb.wrSwSet;

  intc_prio_resolve #(.N(NL), .PW(PW), .IW(IW)) u_resNorm (
    .cand   (pendFlat & ~maskFlat & ~fastQ),
    .prio   (prioQ),
    .anyHit (anyNorm),
    .bestIdx(bestNorm)
  );

  intc_prio_resolve #(.N(NL), .PW(PW), .IW(IW)) u_resFast (
    .cand   (pendFlat & ~maskFlat & fastQ),
    .prio   (prioQ),
    .anyHit (anyFast),
    .bestIdx(bestFast)
  );
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int         NB  = 3,
  parameter int         LPB = 32,
  parameter int         NL  = 96,
  parameter int         PW  = 6,
  parameter int         IW  = 7,
  parameter int         BW  = 2,
  parameter logic [7:0] REV = 8'h21
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [9:0]     regAddr,
  input  logic           wrEn,
  input  logic [2:0]     wrCtl,
  output logic [LPB-1:0] rdData,
  output dpStrobe_t      strb,
  output logic [BW-1:0]  bankSel,
  output logic [IW-1:0]  lineSel,
  input  logic [LPB-1:0] rdRaw,
  input  logic [LPB-1:0] rdMask,
  input  logic [LPB-1:0] rdSw,
  input  logic [LPB-1:0] rdPendN,
  input  logic [LPB-1:0] rdPendF,
  input  logic [PW-1:0]  rdPrio,
  input  logic           rdFast,
  input  logic           evalReq,
  input  logic           anyNorm,
  input  logic           anyFast,
  input  logic [IW-1:0]  bestNorm,
  input  logic [IW-1:0]  bestFast,
  output logic           irqOut,
  output logic           fiqOut,
  output logic           gMaskOn,
  output logic [IW-1:0]  irqVec,
  output logic [IW-1:0]  fiqVec
);
  // global word offsets
  localparam logic [4:0] G_REV = 5'd0, G_CFG = 5'd4, G_STAT = 5'd5,
                         G_VN = 5'd16, G_VF = 5'd17, G_CTL = 5'd18, G_IDLE = 5'd20;

  logic       inGlobal, inBank, bankOk, lineOk, ctlWr;
  logic [1:0] bankIdx, rearm, outQ, agrQ, hasK;
  logic [2:0] off;
  logic [4:0] gOff;
  logic [9:0] lineFull;
  logic       autoIdle, gMaskQ, evalPend;
  logic [1:0] idleQ;
  logic [IW-1:0] vecQ [2];
  logic [IW-1:0] best [2];

  // decode; bank stride of 8 words allows at most four banks
  assign inGlobal = (regAddr[9:5] == 5'd0);
  assign inBank   = (regAddr[9:5] == 5'd1);
  assign gOff     = regAddr[4:0];
  assign bankIdx  = regAddr[4:3];
  assign off      = regAddr[2:0];
  assign bankOk   = inBank && (32'(bankIdx) < NB);
  assign lineFull = regAddr - 10'h040;
  assign lineOk   = (regAddr[9:6] != 4'd0) && (32'(lineFull) < NL);
  assign bankSel  = bankIdx[BW-1:0];
  assign lineSel  = lineFull[IW-1:0];
  assign ctlWr    = wrEn && inGlobal && (gOff == G_CTL);
  assign rearm    = {ctlWr && wrCtl[1], ctlWr && wrCtl[0]};
  assign hasK     = {anyFast, anyNorm};
  assign best[0]  = bestNorm;
  assign best[1]  = bestFast;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (bankOk) begin
        case (off)
          3'd1: strb.wrMask    = 1'b1;
          3'd2: strb.wrMaskClr = 1'b1;
          3'd3: strb.wrMaskSet = 1'b1;
          3'd4: strb.wrSwSet   = 1'b1;
          3'd5: strb.wrSwClr   = 1'b1;
          default: ;
        endcase
      end
      if (lineOk) strb.wrLine = 1'b1;
      if (inGlobal && gOff == G_CFG && wrCtl[1]) strb.softRst = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoIdle <= 1'b0;
      idleQ    <= '0;
      gMaskQ   <= 1'b0;
      evalPend <= 1'b0;
      outQ     <= '0;
      agrQ     <= '1;
      vecQ[0]  <= '0;
      vecQ[1]  <= '0;
    end else if (strb.softRst) begin
      autoIdle <= 1'b0;
      idleQ    <= '0;
      gMaskQ   <= 1'b0;
      evalPend <= 1'b0;
      outQ     <= '0;
      agrQ     <= '1;
      vecQ[0]  <= '0;
      vecQ[1]  <= '0;
    end else begin
      if (wrEn && inGlobal && gOff == G_CFG)  autoIdle <= wrCtl[0];
      if (wrEn && inGlobal && gOff == G_IDLE) idleQ    <= wrCtl[1:0];
      if (ctlWr) gMaskQ <= wrCtl[2];
      evalPend <= evalReq | (|rearm);
      for (int k = 0; k < 2; k++) begin
        if (rearm[k]) begin
          outQ[k] <= 1'b0;
          agrQ[k] <= 1'b1;
        end else if (evalPend && agrQ[k] && hasK[k] && !gMaskQ) begin
          outQ[k] <= 1'b1;
          agrQ[k] <= 1'b0;
          vecQ[k] <= best[k];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (inGlobal) begin
      case (gOff)
        G_REV:  rdData = LPB'(REV);
        G_CFG:  rdData = LPB'(autoIdle);
        G_STAT: rdData = LPB'(1);
        G_VN:   rdData = LPB'(vecQ[0]);
        G_VF:   rdData = LPB'(vecQ[1]);
        G_CTL:  rdData = LPB'({gMaskQ, 2'b00});
        G_IDLE: rdData = LPB'(idleQ);
        default: ;
      endcase
    end else if (bankOk) begin
      case (off)
        3'd0: rdData = rdRaw;
        3'd1: rdData = rdMask;
        3'd4: rdData = rdSw;
        3'd6: rdData = rdPendN;
        3'd7: rdData = rdPendF;
        default: ;
      endcase
    end else if (lineOk) begin
      rdData = LPB'({rdPrio, 1'b0, rdFast});
    end
  end

  assign irqOut  = outQ[0];
  assign fiqOut  = outQ[1];
  assign gMaskOn = gMaskQ;
  assign irqVec  = vecQ[0];
  assign fiqVec  = vecQ[1];
endmodule

// File: rtl/multi_bank_intc.sv
module multi_bank_intc
  import intc_pkg::*;
#(
  parameter int         NB  = 3,
  parameter int         LPB = 32,
  parameter int         PW  = 6,
  parameter logic [7:0] REV = 8'h21
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [9:0]       regAddr,
  input  logic             wrEn,
  input  logic [LPB-1:0]   wrData,
  output logic [LPB-1:0]   rdData,
  input  logic [NB*LPB-1:0] lineIn,
  output logic             irqOut,
  output logic             fiqOut
);
  localparam int NL = NB * LPB;
  localparam int IW = $clog2(NL);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  dpStrobe_t      strb;
  logic [BW-1:0]  bankSel;
  logic [IW-1:0]  lineSel, bestNorm, bestFast, irqVec, fiqVec;
  logic [LPB-1:0] rdRaw, rdMask, rdSw, rdPendN, rdPendF;
  logic [PW-1:0]  rdPrio;
  logic           rdFast, evalReq, anyNorm, anyFast, gMaskOn;

  intc_ctrl #(.NB(NB), .LPB(LPB), .NL(NL), .PW(PW), .IW(IW), .BW(BW), .REV(REV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrCtl(wrData[2:0]),
    .rdData(rdData), .strb(strb), .bankSel(bankSel), .lineSel(lineSel),
    .rdRaw(rdRaw), .rdMask(rdMask), .rdSw(rdSw), .rdPendN(rdPendN), .rdPendF(rdPendF),
    .rdPrio(rdPrio), .rdFast(rdFast), .evalReq(evalReq), .anyNorm(anyNorm),
    .anyFast(anyFast), .bestNorm(bestNorm), .bestFast(bestFast),
    .irqOut(irqOut), .fiqOut(fiqOut), .gMaskOn(gMaskOn), .irqVec(irqVec), .fiqVec(fiqVec)
  );

  intc_datapath #(.NB(NB), .LPB(LPB), .PW(PW), .NL(NL), .IW(IW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bankSel(bankSel), .lineSel(lineSel),
    .wrData(wrData), .lineIn(lineIn), .rdRaw(rdRaw), .rdMask(rdMask), .rdSw(rdSw),
    .rdPendN(rdPendN), .rdPendF(rdPendF), .rdPrio(rdPrio), .rdFast(rdFast),
    .evalReq(evalReq), .anyNorm(anyNorm), .anyFast(anyFast),
    .bestNorm(bestNorm), .bestFast(bestFast)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic [9:0]    regAddr,
  input logic          wrEn,
  input logic [2:0]    wrLow,
  input logic          irqOut,
  input logic          fiqOut,
  input logic          gMaskOn,
  input logic [IW-1:0] irqVec,
  input logic [IW-1:0] fiqVec
);
  logic softWr, ctlWr;
  assign softWr = wrEn && (regAddr == 10'h004) && wrLow[1];
  assign ctlWr  = wrEn && (regAddr == 10'h012);

  AST_RISE_NEEDS_NO_GMASK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqOut) || $rose(fiqOut)) |-> !$past(gMaskOn)); // R6

  AST_SOFT_RESET_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (!irqOut && !fiqOut && irqVec == '0 && fiqVec == '0)); // R10

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(ctlWr && wrLow[0]) && !softWr) |=> (irqOut && $stable(irqVec))); // R5

  AST_FIQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fiqOut && !(ctlWr && wrLow[1]) && !softWr) |=> (fiqOut && $stable(fiqVec))); // R5

  AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && wrLow[0]) |=> !irqOut); // R5
endmodule

bind multi_bank_intc intc_checker #(.IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrLow(wrData[2:0]),
  .irqOut(irqOut), .fiqOut(fiqOut), .gMaskOn(gMaskOn), .irqVec(irqVec), .fiqVec(fiqVec)
);

// File: tb/tb_multi_bank_intc.sv
module tb_multi_bank_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [95:0] lineIn = '0;
  logic        irqOut, fiqOut;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] v;

  always #10 clk = ~clk; // 50 MHz

  multi_bank_intc dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .lineIn(lineIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] val;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h000, 32'h21,       4'd1},  // R1 revision
    '{1'b0, 12'h014, 32'h1,        4'd1},  // R1 status
    '{1'b0, 12'h084, 32'hFFFFFFFF, 4'd7},  // R7 mask reset
    '{1'b1, 12'h088, 32'hF,        4'd7},  // R7 mask clear
    '{1'b0, 12'h084, 32'hFFFFFFF0, 4'd7},
    '{1'b1, 12'h08C, 32'h1,        4'd7},  // R7 mask set
    '{1'b0, 12'h084, 32'hFFFFFFF1, 4'd7},
    '{1'b1, 12'h090, 32'h6,        4'd8},  // R8 software set
    '{1'b0, 12'h090, 32'h6,        4'd8},
    '{1'b0, 12'h098, 32'h6,        4'd3},  // R3 pending normal
    '{1'b1, 12'h104, 32'h1,        4'd4},  // R4 line 1 fast
    '{1'b0, 12'h104, 32'h1,        4'd4},
    '{1'b0, 12'h098, 32'h4,        4'd3},  // R3
    '{1'b0, 12'h09C, 32'h2,        4'd3},  // R3 pending fast
    '{1'b1, 12'h094, 32'h4,        4'd8},  // R8 software clear
    '{1'b0, 12'h098, 32'h0,        4'd8},
    '{1'b0, 12'h09C, 32'h2,        4'd8},
    '{1'b1, 12'h0E8, 32'hFFFFFFFF, 4'd11}, // R11 bank 3 write
    '{1'b0, 12'h0E4, 32'h0,        4'd11},
    '{1'b0, 12'h0C4, 32'hFFFFFFFF, 4'd11},
    '{1'b0, 12'h280, 32'h0,        4'd11}, // R11 line 96
    '{1'b1, 12'h010, 32'h1,        4'd1},  // R1 autoidle
    '{1'b0, 12'h010, 32'h1,        4'd1},
    '{1'b1, 12'h050, 32'h3,        4'd1},  // R1 idle
    '{1'b0, 12'h050, 32'h3,        4'd1},
    '{1'b0, 12'h048, 32'h0,        4'd6}   // R6 global mask off
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a[11:2];
    wrData  = d;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    wrEn    = 1'b0;
    regAddr = a[11:2];
    #2;
    d = rdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({31'b0, irqOut}, 32'h0, "R10 reset irqOut");
    check({31'b0, fiqOut}, 32'h0, "R10 reset fiqOut");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].a, TBL[i].val);
      else begin
        rd(TBL[i].a, v);
        check(v, TBL[i].val, $sformatf("R%0d table entry %0d", TBL[i].rq, i));
      end
    end

    // R10 soft reset clears everything set by the table
    wr(12'h010, 32'h2);
    check({31'b0, irqOut}, 32'h0, "R10 soft reset irq");
    rd(12'h010, v); check(v, 32'h0, "R10 autoidle cleared");
    rd(12'h050, v); check(v, 32'h0, "R10 idle cleared");
    rd(12'h084, v); check(v, 32'hFFFFFFFF, "R10 mask restored");
    rd(12'h104, v); check(v, 32'h0, "R10 line config cleared");

    // R2 level input on line 37 (bank 1 bit 5)
    wr(12'h0A8, 32'h20);
    @(negedge clk); lineIn[37] = 1'b1;
    @(negedge clk);
    check({31'b0, irqOut}, 32'h0, "R2 not yet asserted");
    @(negedge clk);
    check({31'b0, irqOut}, 32'h1, "R2 asserted");
    rd(12'h040, v); check(v, 32'd37, "R2 vector");
    rd(12'h0A0, v); check(v, 32'h20, "R2 raw level");
    rd(12'h0B8, v); check(v, 32'h20, "R3 bank1 pending normal");

    // R4 priority: line 70 prio 3 beats line 37 prio 5
    wr(12'h218, 32'hC);
    wr(12'h194, 32'h14);
    wr(12'h0C8, 32'h40);
    @(negedge clk); lineIn[70] = 1'b1;
    repeat (2) @(negedge clk);
    rd(12'h040, v); check(v, 32'd37, "R5 vector frozen");
    wr(12'h048, 32'h1);
    check({31'b0, irqOut}, 32'h0, "R5 rearm drops");
    @(negedge clk);
    check({31'b0, irqOut}, 32'h1, "R5 reassert");
    rd(12'h040, v); check(v, 32'd70, "R4 lowest priority wins");
    rd(12'h218, v); check(v, 32'hC, "R4 line config readback");

    // R4 tie: line 71 prio 3 beats line 70 prio 3
    wr(12'h21C, 32'hC);
    wr(12'h0C8, 32'h80);
    @(negedge clk); lineIn[71] = 1'b1;
    repeat (2) @(negedge clk);
    wr(12'h048, 32'h1);
    @(negedge clk);
    rd(12'h040, v); check(v, 32'd71, "R4 tie picks higher index");
    rd(12'h040, v); check(v, 32'd71, "R9 vector read again");
    rd(12'h0D8, v); check(v, 32'hC0, "R9 pending kept after vector read");

    // R6 global mask
    wr(12'h048, 32'h5);
    check({31'b0, irqOut}, 32'h0, "R6 drop");
    repeat (3) @(negedge clk);
    check({31'b0, irqOut}, 32'h0, "R6 blocked");
    rd(12'h048, v); check(v, 32'h4, "R1 control readback");
    wr(12'h048, 32'h1);
    @(negedge clk);
    check({31'b0, irqOut}, 32'h1, "R6 released");

    // R8 falling input recomputes pending
    @(negedge clk); lineIn[71] = 1'b0;
    @(negedge clk);
    rd(12'h0D8, v); check(v, 32'h40, "R8 falling edge recompute");
    rd(12'h040, v); check(v, 32'd71, "R5 vector unchanged on fall");

    // R7 mask set does not evaluate, mask clear does
    wr(12'h048, 32'h5);
    wr(12'h048, 32'h0);
    wr(12'h0CC, 32'h40);
    repeat (3) @(negedge clk);
    check({31'b0, irqOut}, 32'h0, "R7 mask set no evaluation");
    wr(12'h088, 32'h1);
    @(negedge clk);
    check({31'b0, irqOut}, 32'h1, "R7 mask clear evaluates");
    rd(12'h040, v); check(v, 32'd37, "R7 vector after mask clear");

    // fast route on line 10
    wr(12'h128, 32'h1);
    wr(12'h088, 32'h400);
    @(negedge clk); lineIn[10] = 1'b1;
    repeat (2) @(negedge clk);
    check({31'b0, fiqOut}, 32'h1, "R2 fast asserted");
    rd(12'h044, v); check(v, 32'd10, "R4 fast vector");
    rd(12'h09C, v); check(v, 32'h400, "R3 pending fast");
    rd(12'h040, v); check(v, 32'd37, "R5 normal untouched");

    // R8 software bit keeps pending through input fall
    wr(12'h090, 32'h400);
    @(negedge clk); lineIn[10] = 1'b0;
    @(negedge clk);
    rd(12'h09C, v); check(v, 32'h400, "R8 software keeps pending");
    wr(12'h094, 32'h400);
    rd(12'h09C, v); check(v, 32'h0, "R8 software clear");

    // R10 soft reset drops outputs
    wr(12'h010, 32'h2);
    check({30'b0, fiqOut, irqOut}, 32'h0, "R10 outputs dropped");
    rd(12'h040, v); check(v, 32'h0, "R10 vector cleared");
    rd(12'h0C4, v); check(v, 32'hFFFFFFFF, "R10 bank2 mask");
    rd(12'h0D8, v); check(v, 32'h0, "R10 pending cleared");

    finishRun();
  end
endmodule